// File: doc/BRIEF.md
# Instruction Operand Field Extractor

This block takes up to three 16-bit words of a fetched instruction and pulls the operand fields that the instruction's descriptors ask for. The descriptors come from the opcode matcher, which lies outside this block. Each descriptor gives an operand type code and a start-bit position. The block handles short signed immediates, an unsigned nibble with an escape value, register and condition-code nibbles, four displacement forms, a 24-bit absolute address and a base-plus-displacement pair. Some encodings split a field into nibble groups whose order is swapped, and the block puts those back in order.

Signed displacements and immediates are not returned in two's complement. Each one is returned as a magnitude, and a single shared flag marks that at least one operand was negative. The decode runs in one combinational pass. Its results are captured on an input strobe, so they appear one clock later together with a valid pulse, and they stay unchanged until the next strobe.

Top module: `opnd_extract`

## Requirements
- R1: After reset, `out_valid` is 0, every result slot is 0 and `op_neg` is 0.
- R2: A cycle with `in_valid` high raises `out_valid` on the next clock only, for exactly one cycle. Results change only on a strobe and hold their values otherwise.
- R3: With `insn_words` = 1, the window is shifted right by 16 before any field is taken, so bits [15:0] of `insn` have no effect. Bit positions below refer to this effective window `e`.
- R4: Type codes 1 to 4 are signed immediates of width code+2 (3 to 6 bits). The field is taken from `e[4+:n]` for a one-word instruction, and otherwise from `e` shifted right by (32 − position). A set top bit raises `op_neg`, and the result is then (2^n − field) mod 2^n.
- R5: Type 7 computes v = 2·e[7:4] + 2. If v bit 5 is set, `op_neg` is raised and the result is (−v) mod 32. Otherwise the result is v.
- R6: Type 8 computes v = {e[11:8], e[3:0], 0} (9 bits). If v bit 8 is set, `op_neg` is raised and the result is (−v) mod 256. Otherwise the result is v.
- R7: Type 9 takes x = e[15:0]. If x is odd, `op_neg` is raised and the result is (−(x−1)) mod 2^16. Otherwise the result is x.
- R8: Type 10 takes x = e[23:0] when `insn_words` = 2. For any other size, x = {e[19:16], e[27:24], e[15:0]}. If x is odd, `op_neg` is raised and the result is (−(x−1)) mod 2^24.
- R9: Type 11 returns {e[19:16], e[27:24], e[15:0]} when `insn_words` = 3, and e[39:16] otherwise. It never raises `op_neg`.
- R10: Type 12 fills two consecutive slots: first {e[27:24], e[15:0]}, then e[19:16]. Every later descriptor moves one slot further along.
- R11: Type 5 takes an unsigned nibble from the same place as R4. A value of 9 is returned as all ones (0xFFFFFF).
- R12: Type 6 returns a register or condition nibble. For one word, it is e[7:4] at position 20, e[3:0] at position 16, and 0 at any other position. For two words, it is the 4 bits of `e` starting at the position. For three words, it is the 4 bits starting at position+16.
- R13: Each decode starts with all slots and `op_neg` cleared. Type 0 ends the walk, so that descriptor and every later one leave their slots at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decode strobe |
| insn | input | 48 | Instruction window |
| insn_words | input | 2 | Instruction size in 16-bit words (1, 2 or 3) |
| desc_type | input | NDESC×4 | Operand type code per descriptor |
| desc_pos | input | NDESC×6 | Start-bit position per descriptor |
| out_valid | output | 1 | Results valid, one cycle after the strobe |
| op_val | output | (NDESC+1)×24 | Result slots |
| op_neg | output | 1 | Shared negative flag |

## Verification
The bench builds the block with the default NDESC = 3, which gives four result slots. With that configuration, a base-plus-displacement operand in the last descriptor lands in the spare slot, and a null code in any of the three positions can be tried. Every short field is swept through all of its values: each immediate width, both displacement nibbles, the escape nibble, and the register positions for every word count. The 16- and 24-bit forms are swept on strided and pseudo-random values, for both the swapped and the plain nibble orders.

// File: rtl/opnd_extract.sv
module opnd_extract #(
  parameter int NDESC = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [47:0]            insn,
  input  logic [1:0]             insn_words,
  input  logic [NDESC-1:0][3:0]  desc_type,
  input  logic [NDESC-1:0][5:0]  desc_pos,
  output logic                   out_valid,
  output logic [NDESC:0][23:0]   op_val,
  output logic                   op_neg
);
  localparam int NSLOT = NDESC + 1;
  localparam logic [3:0] T_NONE = 4'd0, T_UESC = 4'd5, T_REG = 4'd6, T_D5 = 4'd7,
                         T_D9 = 4'd8, T_D17 = 4'd9, T_D25 = 4'd10, T_ABS = 4'd11,
                         T_BASE = 4'd12;

  logic        one_w;
  logic [47:0] e;
  logic [23:0] scr;
  assign one_w = insn_words == 2'd1;
  assign e     = one_w ? {16'h0, insn[47:16]} : insn;
  assign scr   = {e[19:16], e[27:24], e[15:0]};

  logic [NSLOT-1:0][23:0] nv;
  logic                   nn;

  always_comb begin
    logic        run, two;
    int          slot;
    logic [47:0] sh, ps, rs;
    logic [23:0] f, m, v, v2, t24;
    logic [3:0]  f4, rn;
    logic [4:0]  nb;
    logic [5:0]  t6;
    logic [8:0]  t9;
    logic [15:0] t16;
    nv = '0;
    nn = 1'b0;
    run = 1'b1;
    slot = 0;
    for (int d = 0; d < NDESC; d++) begin
      sh  = e >> (7'd32 - {1'b0, desc_pos[d]});
      ps  = e >> desc_pos[d];
      rs  = e >> ({1'b0, desc_pos[d]} + 7'd16);
      nb  = {1'b0, desc_type[d]} + 5'd2;
      m   = (24'd1 << nb) - 24'd1;
      f   = (one_w ? e[27:4] : sh[23:0]) & m;
      f4  = one_w ? e[7:4] : sh[3:0];
      t6  = {1'b0, e[7:4], 1'b0} + 6'd2;
      t9  = {e[11:8], e[3:0], 1'b0};
      t16 = e[15:0];
      t24 = (insn_words == 2'd2) ? e[23:0] : scr;
      case (insn_words)
        2'd1:    rn = (desc_pos[d] == 6'd20) ? e[7:4] : (desc_pos[d] == 6'd16) ? e[3:0] : 4'h0;
        2'd2:    rn = ps[3:0];
        2'd3:    rn = rs[3:0];
        default: rn = 4'h0;
      endcase
      v = '0;
      v2 = '0;
      two = 1'b0;
      if (desc_type[d] == T_NONE) run = 1'b0;
      if (run) begin
        case (desc_type[d])
          4'd1, 4'd2, 4'd3, 4'd4: begin
            v = f;
            if (f[nb - 5'd1]) begin
              nn = 1'b1;
              v = (~f + 24'd1) & m;
            end
          end
          T_UESC: v = (f4 == 4'd9) ? '1 : {20'h0, f4};
          T_REG:  v = {20'h0, rn};
          T_D5: begin
            v = {18'h0, t6};
            if (t6[5]) begin
              nn = 1'b1;
              v = {19'h0, 5'(~t6[4:0] + 5'd1)};
            end
          end
          T_D9: begin
            v = {15'h0, t9};
            if (t9[8]) begin
              nn = 1'b1;
              v = {16'h0, 8'(~t9[7:0] + 8'd1)};
            end
          end
          T_D17: begin
            v = {8'h0, t16};
            if (t16[0]) begin
              nn = 1'b1;
              v = {8'h0, 16'(~{t16[15:1], 1'b0} + 16'd1)};
            end
          end
          T_D25: begin
            v = t24;
            if (t24[0]) begin
              nn = 1'b1;
              v = ~{t24[23:1], 1'b0} + 24'd1;
            end
          end
          T_ABS:  v = (insn_words == 2'd3) ? scr : e[39:16];
          T_BASE: begin
            v   = {4'h0, e[27:24], e[15:0]};
            v2  = {20'h0, e[19:16]};
            two = 1'b1;
          end
          default: v = '0;
        endcase
        for (int k = 0; k < NSLOT; k++) begin
          if (k == slot) nv[k] = v;
          if (two && k == slot + 1) nv[k] = v2;
        end
        slot = slot + (two ? 2 : 1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      op_val    <= '0;
      op_neg    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        op_val <= nv;
        op_neg <= nn;
      end
    end
  end
endmodule

module opnd_extract_chk #(
  parameter int NDESC = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic [NDESC-1:0][3:0] desc_type,
  input logic                  out_valid,
  input logic [NDESC:0][23:0]  op_val,
  input logic                  op_neg
);
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R2
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R2
  AST_HOLD_RESULTS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(op_val) && $stable(op_neg))); // R2
  AST_NULL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && desc_type[0] == 4'd0) |=> (op_val == '0 && !op_neg)); // R13
  AST_ESC_NOT_NINE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && desc_type[0] == 4'd5) |=> (op_val[0] != 24'd9)); // R11
  AST_REG_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && desc_type[0] == 4'd6 && desc_type[1] == 4'd0) |=> (op_val[0] < 24'd16 && !op_neg)); // R12
endmodule

bind opnd_extract opnd_extract_chk #(.NDESC(NDESC)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .desc_type(desc_type),
  .out_valid(out_valid), .op_val(op_val), .op_neg(op_neg)
);

// File: tb/opnd_extract_test.sv
module opnd_extract_test;
  localparam int CLK_PERIOD = 10;
  localparam int ND = 3;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                in_valid = 1'b0;
  logic [47:0]         insn = '0;
  logic [1:0]          insn_words = 2'd2;
  logic [ND-1:0][3:0]  desc_type = '0;
  logic [ND-1:0][5:0]  desc_pos = '0;
  logic                out_valid;
  logic [ND:0][23:0]   op_val;
  logic                op_neg;

  int tests = 0;
  int fails = 0;
  logic [3:0] mt [ND];
  logic [5:0] mp [ND];
  longint unsigned ev [ND+1];
  bit en;
  longint unsigned seed = 64'd12345;

  always #(CLK_PERIOD/2) clk = ~clk;

  opnd_extract #(.NDESC(ND)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn), .insn_words(insn_words),
    .desc_type(desc_type), .desc_pos(desc_pos), .out_valid(out_valid),
    .op_val(op_val), .op_neg(op_neg)
  );

  function automatic longint unsigned nxt();
    seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
    return seed >> 16;
  endfunction

  task automatic check(input bit ok, input string tag, input longint unsigned act, input longint unsigned exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic longint unsigned swz(input longint unsigned e);
    return (e % 65536) + ((e >> 24) % 16) * 65536 + ((e >> 16) % 16) * 1048576;
  endfunction

  task automatic model(input logic [47:0] ins, input int w);
    longint unsigned e, f, x, y, md;
    int slot, n, p;
    bit run, two;
    for (int k = 0; k <= ND; k++) ev[k] = 0;
    en = 0; slot = 0; run = 1;
    e = (w == 1) ? (longint'(ins) >> 16) : longint'(ins);
    for (int d = 0; d < ND; d++) begin
      p = int'(mp[d]);
      x = 0; y = 0; two = 0;
      if (mt[d] == 4'd0) run = 0;
      if (run) begin
        case (mt[d])
          4'd1, 4'd2, 4'd3, 4'd4: begin
            n = int'(mt[d]) + 2;
            md = longint'(1) << n;
            f = ((w == 1) ? (e >> 4) : (e >> (32 - p))) % md;
            if (f >= md / 2) begin en = 1; f = (md - f) % md; end
            x = f;
          end
          4'd5: begin
            f = ((w == 1) ? (e >> 4) : (e >> (32 - p))) % 16;
            x = (f == 9) ? 64'hFFFFFF : f;
          end
          4'd6: begin
            if (w == 1) x = (p == 20) ? (e >> 4) % 16 : (p == 16) ? e % 16 : 0;
            else if (w == 2) x = (e >> p) % 16;
            else if (w == 3) x = (e >> (p + 16)) % 16;
          end
          4'd7: begin
            x = ((e >> 4) % 16) * 2 + 2;
            if (x >= 32) begin en = 1; x = (64 - x) % 32; end
          end
          4'd8: begin
            x = (((e >> 8) % 16) * 16 + e % 16) * 2;
            if (x >= 256) begin en = 1; x = (512 - x) % 256; end
          end
          4'd9: begin
            x = e % 65536;
            if (x % 2 == 1) begin en = 1; x = (65536 - (x - 1)) % 65536; end
          end
          4'd10: begin
            x = (w == 2) ? e % (1 << 24) : swz(e);
            if (x % 2 == 1) begin en = 1; x = ((1 << 24) - (x - 1)) % (1 << 24); end
          end
          4'd11: x = (w == 3) ? swz(e) : (e >> 16) % (1 << 24);
          4'd12: begin
            x = ((e >> 24) % 16) * 65536 + e % 65536;
            y = (e >> 16) % 16;
            two = 1;
          end
          default: x = 0;
        endcase
        if (slot <= ND) ev[slot] = x;
        if (two && slot + 1 <= ND) ev[slot+1] = y;
        slot = slot + (two ? 2 : 1);
      end
    end
  endtask

  task automatic decode(input logic [47:0] ins, input int w, input string tag);
    @(negedge clk);
    insn = ins;
    insn_words = 2'(w);
    for (int d = 0; d < ND; d++) begin
      desc_type[d] = mt[d];
      desc_pos[d] = mp[d];
    end
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    model(ins, w);
    check(out_valid == 1'b1, {tag, " R2 valid"}, longint'(out_valid), 1);
    for (int k = 0; k <= ND; k++)
      check(longint'(op_val[k]) == ev[k], $sformatf("%s slot%0d", tag, k), longint'(op_val[k]), ev[k]);
    check(op_neg == en, {tag, " sign"}, longint'(op_neg), longint'(en));
  endtask

  task automatic set1(input int t, input int p);
    mt[0] = 4'(t); mp[0] = 6'(p);
    mt[1] = 4'd0; mp[1] = 6'd0;
    mt[2] = 4'd0; mp[2] = 6'd0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL R2 watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [23:0] held;
    for (int d = 0; d < ND; d++) begin mt[d] = 0; mp[d] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    check(out_valid == 1'b0, "R1 out_valid", longint'(out_valid), 0);
    check(op_val == '0, "R1 slots", longint'(op_val[0]), 0);
    check(op_neg == 1'b0, "R1 sign", longint'(op_neg), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R6 all even-displacement nibble pairs
    set1(8, 0);
    for (int v = 0; v < 256; v++)
      decode({16'h0, 16'h5A5A, 4'hF, 4'(v >> 4), 4'hC, 4'(v)}, 2, "R6 disp9");

    // R5 and R3: one-word, low half must not matter
    set1(7, 0);
    for (int v = 0; v < 16; v++)
      decode({16'h0, 8'h3C, 4'(v), 4'h9, 16'hFFFF}, 1, "R5 R3 disp5");

    // R4 signed immediates, every width and value, one and two words
    for (int t = 1; t <= 4; t++)
      for (int v = 0; v < (1 << (t + 2)); v++) begin
        set1(t, 12);
        decode({20'hFFFFF, 8'(v), 20'h00000} | (48'(v) << 20), 2, "R4 simm w2");
        decode(48'h0 | (48'hFFFF_FFC0 << 20) | (48'(v) << 20) | 48'hBEEF, 1, "R4 R3 simm w1");
      end

    // R11 escape nibble
    for (int v = 0; v < 16; v++) begin
      set1(5, 8);
      decode(48'hFFFF_F000_0000 | (48'(v) << 24), 2, "R11 esc w2");
      decode(48'h0000_0000_1234 | (48'(v) << 20), 1, "R11 esc w1");
    end

    // R12 register nibble placement
    for (int p = 0; p < 33; p++) begin
      set1(6, p);
      decode(48'hBA98_7654_3210, 1, "R12 reg w1");
      decode(48'hBA98_7654_3210, 2, "R12 reg w2");
      decode(48'hBA98_7654_3210, 3, "R12 reg w3");
    end

    // R7 16-bit displacement
    set1(9, 0);
    for (int v = 0; v < 65536; v += 61) decode({24'h0, 8'hA5, 16'(v)}, 2, "R7 disp17");
    decode(48'h1, 2, "R7 disp17 one");
    decode(48'hFFFF, 2, "R7 disp17 max");

    // R8 and R9: 24-bit forms, both nibble orders
    for (int i = 0; i < 300; i++) begin
      logic [47:0] r;
      r = 48'(nxt());
      set1(10, 0);
      decode(r, 2, "R8 disp25 w2");
      decode(r, 3, "R8 disp25 w3");
      set1(11, 16);
      decode(r, 2, "R9 abs24 w2");
      decode(r, 3, "R9 abs24 w3");
    end

    // R10 two-slot operand at the first and at the last descriptor
    mt[0] = 4'd12; mp[0] = 0; mt[1] = 4'd6; mp[1] = 6'd4; mt[2] = 4'd9; mp[2] = 0;
    decode(48'h0000_7A3B_C4D5, 2, "R10 base first");
    mt[0] = 4'd6; mp[0] = 6'd8; mt[1] = 4'd11; mp[1] = 0; mt[2] = 4'd12; mp[2] = 0;
    decode(48'h1234_5E6F_7081, 2, "R10 base last");

    // R13 null descriptor ends the walk, slots cleared between decodes
    mt[0] = 4'd0; mp[0] = 0; mt[1] = 4'd9; mp[1] = 0; mt[2] = 4'd6; mp[2] = 0;
    decode(48'h0000_0000_FFFF, 2, "R13 null first");
    mt[0] = 4'd9; mt[1] = 4'd0; mt[2] = 4'd11;
    decode(48'h1111_2222_3333, 2, "R13 null middle");
    mt[0] = 4'd6; mp[0] = 0; mt[1] = 4'd0; mt[2] = 4'd0;
    decode(48'h0000_0000_0007, 2, "R13 clear");

    // R2 hold without strobe
    held = op_val[0];
    @(negedge clk);
    insn = 48'hFFFF_FFFF_FFFF;
    desc_type[0] = 4'd9;
    @(negedge clk);
    check(out_valid == 1'b0, "R2 idle valid", longint'(out_valid), 0);
    check(op_val[0] == held, "R2 hold", longint'(op_val[0]), longint'(held));
    check(op_neg == 1'b0, "R2 hold sign", longint'(op_neg), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule